// File: doc/BRIEF.md
# Audio Interface Master Clock Generator

This block drives the two serial-audio timing clocks when the interface is clock master: a bit clock and a frame (left/right) clock, both derived from one master clock. Three rates are offered. In standard mode the bit clock is a divided master clock and every frame holds 64 bit-clock periods, with an even high/low split. In high-rate mode, and in fixed 12 MHz mode, the master clock is passed straight out as the bit clock. The frame then spans a whole number of master-clock cycles. In fixed 12 MHz mode that count is programmable and may be odd, so 375 cycles per frame gives a 187:188 split.

All state moves on the falling edge of the master clock. That edge is a bit-clock falling edge in every mode, so the frame clock never changes elsewhere. A one-cycle frame-start strobe marks the frame-clock rising edge, which opens the left-channel half of the frame. The mode and divide inputs are captured only when a frame begins. Software can therefore write them at any time without producing a runt frame.

Top module: `aif_clk_master`

## Requirements
- R1: While rst_n is low at a master-clock falling edge, lrclk, bclk and frame_start are low and the counters clear, whatever the mode input. At the first falling edge with rst_n high a frame begins: lrclk rises and frame_start is raised.
- R2: Standard mode (mode_sel 2'b00) with divide value D (0 treated as 1): bclk is low for D master cycles and then high for D, starting low at each frame start. A frame is 128*D master cycles, and lrclk is high for the first 64*D of them.
- R3: High-rate mode (mode_sel 2'b01): bclk equals mclk. A frame is HR_FRAME master cycles, lrclk high for the first HR_FRAME/2, and the divide input is ignored.
- R4: Fixed 12 MHz mode (mode_sel 2'b10): bclk equals mclk. A frame is N master cycles with N the divide value (values below 2 act as 2). lrclk is high for the first floor(N/2) cycles and low for the rest, so N=375 gives 187 high and 188 low.
- R5: lrclk changes only at a bclk falling edge. In standard mode, every lrclk change coincides with bclk going from high to low.
- R6: frame_start is high for exactly one master cycle per frame, in the cycle where lrclk has just risen (lrclk high marks the left channel).
- R7: A change of mode_sel or div_sel inside a frame does not alter that frame. It takes effect from the next frame start.
- R8: mode_sel 2'b11 behaves exactly as standard mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all state updates on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Rate mode: 00 standard, 01 high-rate, 10 fixed 12 MHz, 11 standard |
| div_sel | input | DIV_W | Half bit-clock period (standard) or master cycles per frame (fixed 12 MHz) |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock, high for the left channel |
| frame_start | output | 1 | One-cycle strobe at each frame-clock rising edge |

## Verification
The hardest case to reach from the ports is a configuration change that lands partway through a frame. The current frame must then run out under the old length and split, and the new values must apply cleanly at the frame boundary, including switches between divided and pass-through bit clocks. The stimulus walks a chain of configurations and writes the next one into the inputs one cycle into the final frame of each. It then checks the rest of that frame against the old arithmetic. Odd and degenerate frame lengths (2, 3, 7, 375, and the below-minimum values 0 and 1) are included so that the floor/remainder split and the clamping are both exercised.

// File: rtl/aif_clk_pkg.sv
// Shared types for the audio interface master clock generator.
// Assumes a 2-bit mode select; the encoding is fixed by the block's port contract.
package aif_clk_pkg;

    typedef enum logic [1:0] {
        MODE_STD     = 2'b00,
        MODE_HIRATE  = 2'b01,
        MODE_FIXED12 = 2'b10,
        MODE_STD_ALT = 2'b11
    } rate_mode_e;

endpackage

// File: rtl/aif_clk_cfg.sv
// Configuration holder: captures the mode and divide inputs at each frame start
// and derives the prescale, frame length and first-phase length for that frame.
// Assumes load is asserted in the cycle where the counters restart a frame.
module aif_clk_cfg
    import aif_clk_pkg::*;
#(
    parameter int DIV_W    = 10,
    parameter int POS_W    = 10,
    parameter int HR_FRAME = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       mode_in,
    input  logic [DIV_W-1:0] div_in,
    output logic             direct,
    output logic [DIV_W-1:0] pre,
    output logic [POS_W-1:0] len,
    output logic [POS_W-1:0] half
);

    localparam int STD_UNITS = 128;

    rate_mode_e       mode_q;
    logic [DIV_W-1:0] div_q;

    // Capture the requested settings only when a new frame begins.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STD;
            div_q  <= '0;
        end else if (load) begin
            mode_q <= rate_mode_e'(mode_in);
            div_q  <= div_in;
        end
    end

    // Translate the held settings into counter limits.
    always_comb begin
        direct = 1'b0;
        pre    = (div_q == '0) ? DIV_W'(1) : div_q;
        len    = POS_W'(STD_UNITS);
        unique case (mode_q)
            MODE_HIRATE: begin
                direct = 1'b1;
                pre    = DIV_W'(1);
                len    = POS_W'(HR_FRAME);
            end
            MODE_FIXED12: begin
                direct = 1'b1;
                pre    = DIV_W'(1);
                len    = (div_q < DIV_W'(2)) ? POS_W'(2) : POS_W'(div_q);
            end
            default: ;
        endcase
        half = len >> 1;
    end

    // R7: held settings move only at a frame start.
    assert_cfg_hold_R7: assert property (@(negedge clk) disable iff (!rst_n)
        !load |=> (mode_q == $past(mode_q) && div_q == $past(div_q)));

endmodule

// File: rtl/aif_clk_cnt.sv
// Frame position counter: a prescaler of pre master cycles advances a position
// counter that runs from 0 to len-1. It flags each step and each frame restart.
// Assumes pre >= 1 and len >= 2 for the configuration in force.
module aif_clk_cnt #(
    parameter int DIV_W = 10,
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] pre,
    input  logic [POS_W-1:0] len,
    output logic [POS_W-1:0] pos_q,
    output logic             step,
    output logic             wrap,
    output logic             run_q
);

    logic [DIV_W-1:0] sub_q;

    // Decode the end of a prescale period and the end of a frame.
    always_comb begin
        step = (sub_q == pre - DIV_W'(1));
        wrap = !run_q || (step && pos_q == len - POS_W'(1));
    end

    // Advance the prescaler and the position; restart both at frame end.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            sub_q <= '0;
            pos_q <= '0;
            run_q <= 1'b0;
        end else if (wrap) begin
            sub_q <= '0;
            pos_q <= '0;
            run_q <= 1'b1;
        end else if (step) begin
            sub_q <= '0;
            pos_q <= pos_q + POS_W'(1);
        end else begin
            sub_q <= sub_q + DIV_W'(1);
        end
    end

    // R4: the position never runs past the frame length in force.
    assert_pos_range_R4: assert property (@(negedge clk) disable iff (!rst_n)
        run_q |-> (pos_q < len));

    // R2: the prescaler stays inside its period.
    assert_sub_range_R2: assert property (@(negedge clk) disable iff (!rst_n)
        run_q |-> (sub_q < pre));

endmodule

// File: rtl/aif_clk_out.sv
// Output register stage: builds the frame clock, the divided bit clock and the
// frame-start strobe from the counter events. All outputs are registers.
// Assumes wrap and step come from the counter of the same falling edge.
module aif_clk_out #(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             step,
    input  logic [POS_W-1:0] pos_q,
    input  logic [POS_W-1:0] half,
    output logic             lr_q,
    output logic             bit_q,
    output logic             fs_q
);

    logic [POS_W-1:0] pos_nx;

    // Position the counter moves to on a step.
    always_comb pos_nx = pos_q + POS_W'(1);

    // Register the clock levels for the next position and the start strobe.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            lr_q  <= 1'b0;
            bit_q <= 1'b0;
            fs_q  <= 1'b0;
        end else if (wrap) begin
            lr_q  <= 1'b1;
            bit_q <= 1'b0;
            fs_q  <= 1'b1;
        end else begin
            fs_q <= 1'b0;
            if (step) begin
                lr_q  <= (pos_nx < half);
                bit_q <= pos_nx[0];
            end
        end
    end

    // R6: the strobe lasts a single cycle.
    assert_fs_single_R6: assert property (@(negedge clk) disable iff (!rst_n)
        fs_q |=> !fs_q);

    // R6: the strobe coincides with a rising frame clock.
    assert_fs_on_rise_R6: assert property (@(negedge clk) disable iff (!rst_n)
        fs_q |-> (lr_q && !$past(lr_q)));

endmodule

// File: rtl/aif_clk_master.sv
// Audio interface master clock generator top. Wires the configuration holder,
// the frame counter and the output stage, and selects the bit clock source:
// the registered divider in standard mode, the master clock itself otherwise.
// Assumes the master clock is free-running while the block is out of reset.
module aif_clk_master #(
    parameter int DIV_W    = 10,
    parameter int HR_FRAME = 128
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic [DIV_W-1:0] div_sel,
    output logic             bclk,
    output logic             lrclk,
    output logic             frame_start
);

    localparam int POS_W = (DIV_W > 9) ? DIV_W : 9;

    logic             direct;
    logic [DIV_W-1:0] pre;
    logic [POS_W-1:0] len;
    logic [POS_W-1:0] half;
    logic [POS_W-1:0] pos_q;
    logic             step;
    logic             wrap;
    logic             run_q;
    logic             lr_q;
    logic             bit_q;
    logic             fs_q;

    aif_clk_cfg #(.DIV_W(DIV_W), .POS_W(POS_W), .HR_FRAME(HR_FRAME)) u_cfg (
        .clk     (mclk),
        .rst_n   (rst_n),
        .load    (wrap),
        .mode_in (mode_sel),
        .div_in  (div_sel),
        .direct  (direct),
        .pre     (pre),
        .len     (len),
        .half    (half)
    );

    aif_clk_cnt #(.DIV_W(DIV_W), .POS_W(POS_W)) u_cnt (
        .clk   (mclk),
        .rst_n (rst_n),
        .pre   (pre),
        .len   (len),
        .pos_q (pos_q),
        .step  (step),
        .wrap  (wrap),
        .run_q (run_q)
    );

    aif_clk_out #(.POS_W(POS_W)) u_out (
        .clk   (mclk),
        .rst_n (rst_n),
        .wrap  (wrap),
        .step  (step),
        .pos_q (pos_q),
        .half  (half),
        .lr_q  (lr_q),
        .bit_q (bit_q),
        .fs_q  (fs_q)
    );

    // Pick the bit clock source and expose the registered frame signals.
    always_comb begin
        bclk        = direct ? mclk : bit_q;
        lrclk       = lr_q;
        frame_start = fs_q;
    end

    // R5: within divided-clock frames the frame clock moves only as bclk falls.
    assert_lr_on_fall_R5: assert property (@(negedge mclk) disable iff (!rst_n)
        ($past(run_q) && !direct && !$past(direct) && (lr_q != $past(lr_q)))
        |-> ($past(bit_q) && !bit_q));

endmodule

// File: tb/test_aif_clk_master.sv
`timescale 1ns/1ps
module test_aif_clk_master;

    localparam int DIV_W = 10;
    localparam int HR    = 128;

    logic             mclk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [DIV_W-1:0] dv = '0;
    logic             bclk;
    logic             lrclk;
    logic             fs;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    aif_clk_master #(.DIV_W(DIV_W), .HR_FRAME(HR)) i_aif_clk_master (
        .mclk        (mclk),
        .rst_n       (rst_n),
        .mode_sel    (mode),
        .div_sel     (dv),
        .bclk        (bclk),
        .lrclk       (lrclk),
        .frame_start (fs)
    );

    always #4 mclk = ~mclk;
    always @(posedge mclk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int flen(input int m, input int d);
        if (m == 1) return HR;
        if (m == 2) return (d < 2) ? 2 : d;
        return 128 * ((d == 0) ? 1 : d);
    endfunction

    function automatic int fpre(input int m, input int d);
        if (m == 1 || m == 2) return 1;
        return (d == 0) ? 1 : d;
    endfunction

    function automatic string mtag(input int m);
        if (m == 1) return "R3";
        if (m == 2) return "R4";
        if (m == 3) return "R8";
        return "R2";
    endfunction

    // Check n frames of one configuration; load the next one at t==1 of the last.
    task automatic run_frames(input int m, input int d, input int n, input int nm, input int nd);
        int len  = flen(m, d);
        int half = len / 2;
        int pre  = fpre(m, d);
        bit drc  = (m == 1 || m == 2);
        for (int f = 0; f < n; f++) begin
            int lr_bad = 0;
            int fs_bad = 0;
            int bk_bad = 0;
            for (int t = 0; t < len; t++) begin
                if (f == n - 1 && t == 1) begin
                    mode = 2'(nm);
                    dv   = DIV_W'(nd);
                end
                if (lrclk !== (t < half)) lr_bad++;
                if (fs !== (t == 0)) fs_bad++;
                if (bclk !== (drc ? 1'b1 : 1'(((t / pre) % 2)))) bk_bad++;
                if (drc && t == 0) begin
                    @(negedge mclk); #1;
                    if (bclk !== 1'b0) bk_bad++;
                end
                @(posedge mclk); #1;
            end
            // lrclk shape and split; R5: in divided mode edges sit where bclk falls
            chk(lr_bad == 0, {mtag(m), "/R5 lrclk mismatches"}, lr_bad, 0);
            chk(fs_bad == 0, "R6 frame_start mismatches", fs_bad, 0);
            chk(bk_bad == 0, {mtag(m), " bclk mismatches"}, bk_bad, 0);
            if (f == n - 1)
                chk(lr_bad + fs_bad + bk_bad == 0, "R7 old settings held to frame end",
                    lr_bad + fs_bad + bk_bad, 0);
        end
    endtask

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int cm[14];
        int cd[14];
        cm = '{0, 0, 0, 1, 2, 2, 2, 2, 2, 2, 3, 0, 1, 2};
        cd = '{1, 2, 3, 5, 375, 2, 3, 0, 1, 7, 2, 0, 0, 4};

        // R1: reset held with a pass-through mode requested
        mode = 2'b10;
        dv   = DIV_W'(9);
        repeat (3) @(posedge mclk);
        #1;
        chk(lrclk === 1'b0, "R1 lrclk in reset", int'(lrclk), 0);
        chk(bclk === 1'b0, "R1 bclk in reset", int'(bclk), 0);
        chk(fs === 1'b0, "R1 frame_start in reset", int'(fs), 0);
        mode = 2'(cm[0]);
        dv   = DIV_W'(cd[0]);
        rst_n = 1'b1;
        @(posedge mclk); #1;
        chk(fs === 1'b1 && lrclk === 1'b1, "R1 first frame starts at once",
            int'({fs, lrclk}), 3);

        for (int i = 0; i < 13; i++)
            run_frames(cm[i], cd[i], 2, cm[i + 1], cd[i + 1]);

        // R1: reset in the middle of a pass-through frame
        #2;
        rst_n = 1'b0;
        @(posedge mclk); #1;
        chk(lrclk === 1'b0 && fs === 1'b0, "R1 lrclk/frame_start after reset",
            int'({lrclk, fs}), 0);
        chk(bclk === 1'b0, "R1 bclk back to divided source", int'(bclk), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule